// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block connects a clocked host to an asynchronous static memory made of several dies that share a 39-bit data bus and a 19-bit address bus, each die with its own active-low enable. The host gives one request at a time through a valid/ready handshake: a direction bit, an address, a die index and, for writes, a data word. Reads come back as a one-cycle response pulse carrying the word. Writes finish without a response.

Every analogue timing limit of the memory is turned into a cycle count. The conversion divides each nanosecond minimum by the clock period parameter, rounds up and never goes below one cycle. The controller always puts the address on the bus one cycle before any die enable falls, and holds it until the enable has risen again. This matters because the memory starts an internal sense on every enable edge and on every address change while enabled. After reset the block holds off all traffic for a configurable wake-up interval, 100 ms by default, while the memory's own power-on logic settles. The bench shortens this interval.

The write data driver turns on only once the memory's outputs are known to be off. A read that follows a write gets one extra cycle with every strobe high, so the data bus can turn around.

Top module: `sram_bus_ctl`

## Requirements
- R1: From reset release until the wake-up count has run out, `host_req_ready` is low, every bit of `mem_die_n` is high, `mem_we_n` and `mem_oe_n` are high and `mem_dq_oe` is low. With a 5 ns clock and a 500 ns wake-up, `host_req_ready` first reads high after the 101st rising edge following reset release.
- R2: Die index d (0 to 7) drives bit d of `mem_die_n` low during that die's access. No more than one bit of `mem_die_n` is ever low.
- R3: In the cycle after a request is taken (after the turnaround cycle, if one is inserted), the new address is on `mem_addr` with all die enables high. The address does not change while any die enable is low.
- R4: A read holds the chosen die enable and `mem_oe_n` low, with `mem_we_n` high, for ceil(20 ns / CLK_NS) cycles (4 at 5 ns). It samples `mem_dq_in` in the last of those cycles. It then releases every strobe.
- R5: The read response is a single-cycle pulse on `host_rsp_valid` with the sampled word on `host_rsp_rdata`. The pulse comes in the cycle right after the last enabled read cycle, and `host_req_ready` is high again in that same cycle.
- R6: A write holds the chosen die enable and `mem_we_n` low with `mem_oe_n` high for max(ceil(8/CLK), ceil(10/CLK), ceil(7/CLK)+ceil(5/CLK)) cycles (3 at 5 ns). `mem_dq_oe` stays low for the first ceil(7/CLK) of them (2 at 5 ns).
- R7: Write data sits on `mem_dq_out` with `mem_dq_oe` high from the first driven strobe cycle through ceil(2/CLK) cycles after `mem_we_n` rises (1 at 5 ns). The die enables are high during that hold.
- R8: A read accepted right after a write first spends one cycle with all strobes high and `mem_dq_oe` low, and only then presents its address. A read after a read gets no such cycle.
- R9: `host_req_ready` is low while an access is in progress. A request presented while `host_req_ready` is low starts no memory access.
- R10: A write never produces a `host_rsp_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, period CLK_NS |
| rst_n | input | 1 | Synchronous reset, active low |
| host_req_valid | input | 1 | Host request present |
| host_req_ready | output | 1 | Controller can take a request this cycle |
| host_req_write | input | 1 | 1 = write, 0 = read |
| host_req_addr | input | 19 | Word address |
| host_req_die | input | 3 | Die index |
| host_req_wdata | input | 39 | Write data |
| host_rsp_valid | output | 1 | One-cycle read response strobe |
| host_rsp_rdata | output | 39 | Read data |
| mem_addr | output | 19 | Memory address bus |
| mem_die_n | output | 8 | Per-die enables, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_in | input | 39 | Data bus as seen from the memory |
| mem_dq_out | output | 39 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Data driver enable |

## Verification
The hardest cases to reach are the short turnaround cycle that only appears when a read follows a write, and a request arriving while the controller is busy. The bench reaches the first by issuing a read immediately after a write completes. It checks that cycle as a separate step in the captured strobe trace. For the second, it raises the request strobe in the middle of a read. It then watches the enables stay high for several cycles after the read finishes, and reads back the target location to confirm it still holds its earlier contents.

// File: rtl/sram_bus_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the asynchronous SRAM bus controller.
// Assumes timing figures are given as whole nanoseconds.
package sram_bus_pkg;

    typedef enum logic [2:0] {
        ST_WAKE,   // wake-up hold-off after reset
        ST_IDLE,   // waiting for a host request
        ST_TURN,   // bus turnaround before a read that follows a write
        ST_ADDR,   // address presented, enables still high
        ST_READ,   // die enabled with outputs on
        ST_WLOW,   // write strobe low
        ST_WHOLD   // data held after the strobe rises
    } ctl_state_e;

    // Turn a nanosecond minimum into a clock count, rounding up, at least one.
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
        int unsigned c;
        c = (ns + clk_ns - 1) / clk_ns;
        if (c == 0) c = 1;
        return c;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_wake_timer.sv
`timescale 1ns/1ps
// Wake-up hold-off: counts clock cycles after reset release and raises
// wake_done once LIMIT cycles have elapsed. Assumes LIMIT >= 1.
module sram_wake_timer #(
    parameter int unsigned LIMIT = 20_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic wake_done
);
    localparam int unsigned CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT);

    logic [CW-1:0] cnt_q;

    // Count up to the limit and stop there.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
    end

    assign wake_done = (cnt_q == LAST);
endmodule

// File: rtl/sram_die_decode.sv
`timescale 1ns/1ps
// Die-enable decoder: turns a die index into active-low one-hot enables,
// all high when en is low. An index beyond DIES selects nothing.
module sram_die_decode #(
    parameter int unsigned DIES  = 8,
    parameter int unsigned DIE_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIE_W-1:0] sel,
    output logic [DIES-1:0]  die_n
);
    // One comparator per die enable.
    for (genvar g = 0; g < DIES; g++) begin : g_die
        assign die_n[g] = !(en && (sel == DIE_W'(g)));
    end

    // R2: never more than one die enabled
    a_r2_one_die: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~die_n));
endmodule

// File: rtl/sram_bus_ctl.sv
`timescale 1ns/1ps
// Synchronous controller for a multi-die asynchronous SRAM. It takes one
// host request at a time and sequences address, die enable, write strobe,
// output enable and the data driver so that every memory timing minimum
// holds as a whole number of clock cycles. Assumes CLK_NS is the true clock
// period and that mem_dq_in is already synchronous to clk where sampled.
module sram_bus_ctl
    import sram_bus_pkg::*;
#(
    parameter int unsigned ADDR_W    = 19,
    parameter int unsigned DATA_W    = 39,
    parameter int unsigned DIES      = 8,
    parameter int unsigned CLK_NS    = 5,
    parameter int unsigned WAKE_NS   = 100_000_000,
    parameter int unsigned T_ACC_NS  = 20,
    parameter int unsigned T_RCYC_NS = 20,
    parameter int unsigned T_WCYC_NS = 10,
    parameter int unsigned T_WPW_NS  = 8,
    parameter int unsigned T_DSU_NS  = 5,
    parameter int unsigned T_DHD_NS  = 2,
    parameter int unsigned T_WOFF_NS = 7,
    parameter int unsigned T_WGAP_NS = 1,
    parameter int unsigned DIE_W     = $clog2(DIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req_valid,
    output logic              host_req_ready,
    input  logic              host_req_write,
    input  logic [ADDR_W-1:0] host_req_addr,
    input  logic [DIE_W-1:0]  host_req_die,
    input  logic [DATA_W-1:0] host_req_wdata,
    output logic              host_rsp_valid,
    output logic [DATA_W-1:0] host_rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DIES-1:0]   mem_die_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe
);
    // Cycle budgets derived from the nanosecond minimums.
    localparam int unsigned WAKE_CYC = ns_to_cyc(WAKE_NS, CLK_NS);
    localparam int unsigned RD_CYC   = max2(ns_to_cyc(T_ACC_NS, CLK_NS), ns_to_cyc(T_RCYC_NS, CLK_NS));
    localparam int unsigned OFF_CYC  = ns_to_cyc(T_WOFF_NS, CLK_NS);
    localparam int unsigned WL_CYC   = max2(max2(ns_to_cyc(T_WPW_NS, CLK_NS), ns_to_cyc(T_WCYC_NS, CLK_NS)),
                                            OFF_CYC + ns_to_cyc(T_DSU_NS, CLK_NS));
    localparam int unsigned HD_CYC   = max2(ns_to_cyc(T_DHD_NS, CLK_NS), ns_to_cyc(T_WGAP_NS, CLK_NS));
    localparam int unsigned CNT_W    = $clog2(max2(max2(RD_CYC, WL_CYC), HD_CYC) + 1);
    localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] WL_LAST = CNT_W'(WL_CYC - 1);
    localparam logic [CNT_W-1:0] HD_LAST = CNT_W'(HD_CYC - 1);
    localparam logic [CNT_W-1:0] OFF_LIM = CNT_W'(OFF_CYC);

    ctl_state_e        state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DIE_W-1:0]  die_q;
    logic [DATA_W-1:0] wdata_q;
    logic              is_wr_q;
    logic              after_wr_q;
    logic              rsp_q;
    logic [DATA_W-1:0] rdata_q;
    logic              wake_done;
    logic              die_on;
    logic              take;

    sram_wake_timer #(.LIMIT(WAKE_CYC)) u_wake (
        .clk       (clk),
        .rst_n     (rst_n),
        .wake_done (wake_done)
    );

    assign die_on = (state_q == ST_READ) || (state_q == ST_WLOW);

    sram_die_decode #(.DIES(DIES), .DIE_W(DIE_W)) u_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (die_on),
        .sel   (die_q),
        .die_n (mem_die_n)
    );

    assign host_req_ready = (state_q == ST_IDLE);
    assign take           = host_req_valid && host_req_ready;

    // Strobe and data-driver decode from the registered phase.
    always_comb begin
        mem_addr       = addr_q;
        mem_dq_out     = wdata_q;
        mem_we_n       = (state_q != ST_WLOW);
        mem_oe_n       = (state_q != ST_READ);
        mem_dq_oe      = ((state_q == ST_WLOW) && (cnt_q >= OFF_LIM)) || (state_q == ST_WHOLD);
        host_rsp_valid = rsp_q;
        host_rsp_rdata = rdata_q;
    end

    // Access sequencer: phase, phase counter, request capture and response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_WAKE;
            cnt_q      <= '0;
            addr_q     <= '0;
            die_q      <= '0;
            wdata_q    <= '0;
            is_wr_q    <= 1'b0;
            after_wr_q <= 1'b0;
            rsp_q      <= 1'b0;
            rdata_q    <= '0;
        end else begin
            rsp_q <= 1'b0;
            cnt_q <= '0;
            case (state_q)
                ST_WAKE: if (wake_done) state_q <= ST_IDLE;
                ST_IDLE: begin
                    if (take) begin
                        addr_q  <= host_req_addr;
                        die_q   <= host_req_die;
                        wdata_q <= host_req_wdata;
                        is_wr_q <= host_req_write;
                        if (!host_req_write && after_wr_q) state_q <= ST_TURN;
                        else                               state_q <= ST_ADDR;
                        if (!host_req_write) after_wr_q <= 1'b0;
                    end
                end
                ST_TURN: state_q <= ST_ADDR;
                ST_ADDR: state_q <= is_wr_q ? ST_WLOW : ST_READ;
                ST_READ: begin
                    if (cnt_q == RD_LAST) begin
                        rdata_q <= mem_dq_in;
                        rsp_q   <= 1'b1;
                        state_q <= ST_IDLE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_WLOW: begin
                    if (cnt_q == WL_LAST) state_q <= ST_WHOLD;
                    else                  cnt_q   <= cnt_q + 1'b1;
                end
                ST_WHOLD: begin
                    if (cnt_q == HD_LAST) begin
                        after_wr_q <= 1'b1;
                        state_q    <= ST_IDLE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Checker counters: lengths of the current read-enable and write-strobe runs.
    logic [7:0] rd_run_q, we_run_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_run_q <= '0;
            we_run_q <= '0;
        end else begin
            rd_run_q <= (!mem_oe_n && mem_we_n && (mem_die_n != '1)) ? ((rd_run_q == 8'hFF) ? rd_run_q : rd_run_q + 1'b1) : '0;
            we_run_q <= !mem_we_n ? ((we_run_q == 8'hFF) ? we_run_q : we_run_q + 1'b1) : '0;
        end
    end

    // R1: nothing moves before the wake-up interval has run out
    a_r1_quiet_wake: assert property (@(posedge clk) disable iff (!rst_n)
        !wake_done |-> (!host_req_ready && (mem_die_n == '1) && mem_we_n && mem_oe_n && !mem_dq_oe));

    // R3: address unchanged on the cycle an enable falls and while it stays low
    a_r3_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_die_n != '1) |-> $stable(mem_addr));

    // R4: a response only after the full access window with outputs enabled
    a_r4_read_window: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_rsp_valid) |-> (rd_run_q >= 8'(RD_CYC)));

    // R6: write data not driven before the memory outputs have turned off
    a_r6_drive_late: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_dq_oe && !mem_we_n) |-> (we_run_q >= 8'(OFF_CYC)));

    // R6: outputs disabled whenever the write strobe is low
    a_r6_oe_off_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);

    // R7: never drive while the memory may be driving
    a_r7_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    // R9: ready only with every die idle
    a_r9_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
        host_req_ready |-> ((mem_die_n == '1) && !mem_dq_oe));

    // R10: a response pulse follows only an output-enabled cycle
    a_r10_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        host_rsp_valid |-> $past(!mem_oe_n));
endmodule

// File: tb/test_sram_bus_ctl.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own captured trace.
module test_sram_bus_ctl;
    localparam int WAKE_CYC = 100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req_valid = 1'b0;
    logic        host_req_ready;
    logic        host_req_write = 1'b0;
    logic [18:0] host_req_addr = '0;
    logic [2:0]  host_req_die = '0;
    logic [38:0] host_req_wdata = '0;
    logic        host_rsp_valid;
    logic [38:0] host_rsp_rdata;
    logic [18:0] mem_addr;
    logic [7:0]  mem_die_n;
    logic        mem_we_n, mem_oe_n, mem_dq_oe;
    logic [38:0] mem_dq_in, mem_dq_out;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    sram_bus_ctl #(.CLK_NS(5), .WAKE_NS(500)) i_sram_bus_ctl (
        .clk(clk), .rst_n(rst_n),
        .host_req_valid(host_req_valid), .host_req_ready(host_req_ready),
        .host_req_write(host_req_write), .host_req_addr(host_req_addr),
        .host_req_die(host_req_die), .host_req_wdata(host_req_wdata),
        .host_rsp_valid(host_rsp_valid), .host_rsp_rdata(host_rsp_rdata),
        .mem_addr(mem_addr), .mem_die_n(mem_die_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_dq_in(mem_dq_in), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe)
    );

    // Memory model: 8 dies x 16 words, keyed by die and low address nibble.
    logic [38:0] mem_arr [0:127];
    logic [2:0]  m_die;
    logic        m_sel;

    function automatic logic [38:0] pat(input int k);
        return 39'h2A5A5A5A5A ^ 39'(k * 39'h10101);
    endfunction

    always_comb begin
        m_sel = 1'b0;
        m_die = '0;
        for (int i = 0; i < 8; i++) if (!mem_die_n[i]) begin m_sel = 1'b1; m_die = 3'(i); end
        mem_dq_in = (m_sel && !mem_oe_n && mem_we_n) ? mem_arr[{m_die, mem_addr[3:0]}] : '0;
    end

    always @(posedge clk)
        if (rst_n && m_sel && !mem_we_n && mem_dq_oe) mem_arr[{m_die, mem_addr[3:0]}] <= mem_dq_out;

    // Expected contents, independent of the model's storage.
    logic [38:0] sb [int];
    function automatic logic [38:0] expect_word(input logic [2:0] d, input logic [18:0] a);
        int k;
        k = int'({d, a[3:0]});
        return sb.exists(k) ? sb[k] : pat(k);
    endfunction

    // Captured trace, one entry per cycle after the accept edge.
    logic [7:0]  t_die [0:11];
    logic        t_we [0:11], t_oe [0:11], t_doe [0:11], t_rsp [0:11], t_rdy [0:11];
    logic [18:0] t_addr [0:11];
    logic [38:0] t_dout [0:11], t_rdat [0:11];

    task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", rq, act, exp, $time);
        end
    endtask

    // Issue one request and record n cycles; optionally raise a stray request at cycle inj.
    task automatic issue(input bit wr, input logic [2:0] d, input logic [18:0] a,
                         input logic [38:0] wd, input int n, input int inj);
        @(negedge clk);
        while (!host_req_ready) @(negedge clk);
        host_req_valid = 1'b1; host_req_write = wr; host_req_die = d;
        host_req_addr = a; host_req_wdata = wd;
        @(posedge clk);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            t_die[k] = mem_die_n; t_we[k] = mem_we_n; t_oe[k] = mem_oe_n;
            t_doe[k] = mem_dq_oe; t_rsp[k] = host_rsp_valid; t_rdy[k] = host_req_ready;
            t_addr[k] = mem_addr; t_dout[k] = mem_dq_out; t_rdat[k] = host_rsp_rdata;
            if (k == 0) host_req_valid = 1'b0;
            if (k == inj) begin
                host_req_valid = 1'b1; host_req_write = 1'b1; host_req_die = 3'd6;
                host_req_addr = 19'h00009; host_req_wdata = 39'h7FFFFFFFFF;
            end
            if (k == inj + 2) host_req_valid = 1'b0;
        end
    endtask

    task automatic t_wake;
        int n;
        n = 0;
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        chk(!host_req_ready && mem_die_n == 8'hFF && mem_we_n && mem_oe_n && !mem_dq_oe && !host_rsp_valid,
            "R1 reset state", {mem_die_n, mem_we_n, mem_oe_n, mem_dq_oe}, {8'hFF, 3'b110});
        while (!host_req_ready && n < 1000) begin
            @(posedge clk); n++;
            @(negedge clk);
            if (n == 10) begin host_req_valid = 1'b1; host_req_write = 1'b0; end
            if (n == 40) host_req_valid = 1'b0;
            if (!host_req_ready && (mem_die_n != 8'hFF || !mem_we_n || !mem_oe_n || mem_dq_oe)) begin
                chk(1'b0, "R1 R9 strobe moved during wake-up", {mem_die_n, mem_we_n, mem_oe_n}, {8'hFF, 2'b11});
            end
        end
        chk(n == WAKE_CYC + 1, "R1 wake-up length", n, WAKE_CYC + 1);
        repeat (3) @(negedge clk);
        chk(mem_die_n == 8'hFF && host_req_ready, "R9 early request ignored", mem_die_n, 8'hFF);
    endtask

    task automatic t_write(input logic [2:0] d, input logic [18:0] a, input logic [38:0] wd);
        logic [7:0] on;
        on = ~(8'h01 << d);
        issue(1'b1, d, a, wd, 8, -1);
        sb[int'({d, a[3:0]})] = wd;
        chk(t_die[0] == 8'hFF && t_addr[0] == a, "R3 write address before enable", {t_die[0], t_addr[0]}, {8'hFF, a});
        for (int k = 1; k <= 3; k++) begin
            chk(t_die[k] == on && !t_we[k] && t_oe[k], "R2 R6 write strobe", {t_die[k], t_we[k], t_oe[k]}, {on, 2'b01});
            chk(t_doe[k] == (k >= 3), "R6 driver waits for outputs off", t_doe[k], (k >= 3));
            chk(t_addr[k] == a, "R3 write address held", t_addr[k], a);
        end
        chk(t_dout[3] == wd, "R7 data before strobe rises", t_dout[3], wd);
        chk(t_we[4] && t_die[4] == 8'hFF && t_doe[4] && t_dout[4] == wd, "R7 data hold",
            {t_we[4], t_die[4], t_doe[4], t_dout[4]}, {1'b1, 8'hFF, 1'b1, wd});
        chk(!t_doe[5] && t_rdy[5], "R7 driver released", {t_doe[5], t_rdy[5]}, 2'b01);
        for (int k = 0; k < 8; k++) chk(!t_rsp[k], "R10 no response on write", t_rsp[k], 1'b0);
    endtask

    task automatic t_read(input logic [2:0] d, input logic [18:0] a, input bit turn);
        int o;
        logic [38:0] ex;
        logic [7:0] on;
        o = turn ? 1 : 0;
        on = ~(8'h01 << d);
        ex = expect_word(d, a);
        issue(1'b0, d, a, '0, o + 7, -1);
        if (turn)
            chk(t_die[0] == 8'hFF && t_we[0] && t_oe[0] && !t_doe[0] && !t_rdy[0], "R8 turnaround cycle",
                {t_die[0], t_we[0], t_oe[0], t_doe[0]}, {8'hFF, 3'b110});
        chk(t_die[o] == 8'hFF && t_addr[o] == a && !t_rdy[o], "R3 R8 read address before enable",
            {t_die[o], t_addr[o]}, {8'hFF, a});
        for (int k = o + 1; k <= o + 4; k++) begin
            chk(t_die[k] == on && !t_oe[k] && t_we[k] && t_addr[k] == a, "R2 R4 read window",
                {t_die[k], t_oe[k], t_we[k], t_addr[k]}, {on, 2'b01, a});
            chk(!t_rsp[k] && !t_rdy[k], "R5 R9 busy, no early response", {t_rsp[k], t_rdy[k]}, 2'b00);
        end
        chk(t_rsp[o + 5] && t_rdy[o + 5] && t_die[o + 5] == 8'hFF, "R4 R5 response timing",
            {t_rsp[o + 5], t_rdy[o + 5], t_die[o + 5]}, {2'b11, 8'hFF});
        chk(t_rdat[o + 5] == ex, "R5 read data", t_rdat[o + 5], ex);
        chk(!t_rsp[o + 6], "R5 single-cycle pulse", t_rsp[o + 6], 1'b0);
    endtask

    task automatic t_busy_ignore;
        issue(1'b0, 3'd7, 19'h7FFFF, '0, 10, 1);
        for (int k = 6; k < 10; k++)
            chk(t_die[k] == 8'hFF && t_we[k], "R9 stray request started nothing", {t_die[k], t_we[k]}, {8'hFF, 1'b1});
        t_read(3'd6, 19'h00009, 1'b0);
    endtask

    initial begin
        for (int i = 0; i < 128; i++) mem_arr[i] = pat(i);
        t_wake();
        t_write(3'd0, 19'h00000, 39'h123456789A);
        t_write(3'd7, 19'h7FFFF, 39'h7FFFFFFFFF);
        t_read (3'd0, 19'h00000, 1'b1);
        t_read (3'd7, 19'h7FFFF, 1'b0);
        t_write(3'd3, 19'h2A5A3, 39'h0F0F0F0F0F);
        t_write(3'd3, 19'h15A5C, 39'h50A050A050);
        t_read (3'd3, 19'h2A5A3, 1'b1);
        t_read (3'd3, 19'h15A5C, 1'b0);
        t_read (3'd5, 19'h00000, 1'b0);
        t_busy_ignore();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule